// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is the device-side command interpreter of a serial flash memory. It sits on a four-wire SPI bus in mode 0 (select, clock, data in, data out). It oversamples the bus pins with its own system clock. From the bit stream it assembles an opcode and any address, dummy or data bytes. It then either streams bytes back to the host or hands a finished write-type operation to an internal execution engine. The memory array is not part of the block. Instead, a narrow request port asks an external backend to read a byte, write a byte, clear a 64 KiB sector or clear the whole array. The backend decodes the sector from address bits 23:16.

The block holds the status register. Bit 0 shows an operation in progress and bit 1 is the write-enable latch. Bits 7:2 are a general field that the status-write command loads. A page program first collects up to one page of data in a local buffer. It writes that buffer to the backend only after the select line is released. A configurable busy period then follows before the host sees the device as ready again.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: Bits move most significant bit first. SI is taken at each rising SCK edge while CS# is low, and SO changes only on falling SCK edges. `spi_miso_oe` is 0 out of reset, 0 whenever CS# is high, and 1 only during the data-return phase of an accepted read-type command.
- R2: Opcodes: 0x06 set write enable, 0x04 clear write enable, 0x05 status read, 0x01 status write, 0x03 read, 0x0B fast read, 0x02 page program, 0xD8 sector clear, 0xC7 full clear, 0x9F identification read.
- R3: Status read returns {field[7:2], write-enable, busy}. It repeats that live byte for as long as the clock runs, and it is accepted while busy. The status is 0x00 after reset.
- R4: Identification read returns the three bytes of parameter `DEV_ID`, high byte first, and then repeats them in the same order.
- R5: Read takes a 24-bit address in three bytes and returns data from the following byte onward. Fast read first inserts one dummy byte. Both increment the address after each byte returned.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it.
- R7: Write-type commands (0x06, 0x04, 0x01, 0x02, 0xD8, 0xC7) take effect only if CS# rises after a multiple of eight SCK rising edges. The frame must also be long enough: one byte for 0x06, 0x04 and 0xC7, two bytes for 0x01, four bytes for 0xD8, and at least five bytes for 0x02. Any other frame leaves state and array untouched.
- R8: Page program, sector clear, full clear and status write are discarded unless the write-enable latch is set.
- R9: Page program writes each data byte at the page offset of the start address plus its index modulo 256, and stays within the same 256-byte page.
- R10: A committed sector clear or full clear emits one request pulse that carries the address. A committed status write loads bits 7:2 of its data byte into the status field.
- R11: A committed status write, program or clear sets busy for the write time plus `BUSY_CYCLES` system clocks. Busy and the write-enable latch then both clear. While busy, every command except status read is ignored, and no data is driven.
- R12: An unknown opcode is ignored until CS# rises, with SO not driven. Raising CS# in the middle of a read byte ends the transfer, and the next frame behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Bus select, active low |
| spi_sck | input | 1 | Bus clock, mode 0 |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| mem_addr | output | 24 | Array address for every request |
| mem_rd_req | output | 1 | Read pulse; data expected on `mem_rd_data` one clock later |
| mem_rd_data | input | 8 | Read data from the backend |
| mem_wr_req | output | 1 | Byte write pulse |
| mem_wr_data | output | 8 | Byte to write |
| mem_erase_sector | output | 1 | Clear the sector holding `mem_addr` |
| mem_erase_all | output | 1 | Clear the full array |

## Verification
The status byte is the main window into the block. A wrong write-enable or busy state appears in the next status read, within one byte time. A write-type frame that commits when it should be rejected, or the reverse, appears either in that status byte or in the array contents on the next read. A wrong page offset or address counter shows up as a byte mismatch at the exact position on readback. A drive-enable error shows as `spi_miso_oe` out of step with the opcode during the first data byte.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int ADDR_W = 24;
  localparam int PAGE_W = 8;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_SE    = 8'hD8;
  localparam logic [7:0] OP_BE    = 8'hC7;
  localparam logic [7:0] OP_RDID  = 8'h9F;

  typedef enum logic [3:0] {
    C_NONE, C_WREN, C_WRDI, C_RDSR, C_WRSR, C_READ,
    C_FREAD, C_PP, C_SE, C_BE, C_RDID
  } cmd_e;

  function automatic logic needs_wel(cmd_e c);
    return (c == C_PP) || (c == C_SE) || (c == C_BE) || (c == C_WRSR);
  endfunction

  function automatic logic is_write(cmd_e c);
    return needs_wel(c) || (c == C_WREN) || (c == C_WRDI);
  endfunction

  // shortest legal frame, in whole bytes
  function automatic logic [2:0] min_bytes(cmd_e c);
    case (c)
      C_WREN, C_WRDI, C_BE: return 3'd1;
      C_WRSR:               return 3'd2;
      C_SE:                 return 3'd4;
      C_PP:                 return 3'd5;
      default:              return 3'd7;
    endcase
  endfunction

  function automatic cmd_e op_decode(logic [7:0] op, logic busy, logic wel);
    cmd_e c;
    case (op)
      OP_WREN:  c = C_WREN;
      OP_WRDI:  c = C_WRDI;
      OP_RDSR:  c = C_RDSR;
      OP_WRSR:  c = C_WRSR;
      OP_READ:  c = C_READ;
      OP_FREAD: c = C_FREAD;
      OP_PP:    c = C_PP;
      OP_SE:    c = C_SE;
      OP_BE:    c = C_BE;
      OP_RDID:  c = C_RDID;
      default:  c = C_NONE;
    endcase
    if (busy && (c != C_RDSR)) c = C_NONE;
    if (needs_wel(c) && !wel)  c = C_NONE;
    return c;
  endfunction

endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_n_q_o,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic mosi_q_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b100;

  logic [NPIN-1:0] raw_w, synced_w;
  logic [1:0]      prev_q;

  assign raw_w = {cs_n_i, sck_i, mosi_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{PIN_RST[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], raw_w[g]};
    end
    assign synced_w[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b10;
    else        prev_q <= synced_w[2:1];
  end

  assign cs_n_q_o   = synced_w[2];
  assign cs_rise_o  =  synced_w[2] & ~prev_q[1];
  assign cs_fall_o  = ~synced_w[2] &  prev_q[1];
  assign sck_rise_o =  synced_w[1] & ~prev_q[0];
  assign sck_fall_o = ~synced_w[1] &  prev_q[0];
  assign mosi_q_o   = synced_w[0];
endmodule

// File: rtl/sfc_cmd.sv
module sfc_cmd
  import sfc_pkg::*;
#(
  parameter logic [23:0] DEV_ID = 24'hA53C19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_q,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_q,
  input  logic [7:0]        status_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              pb_we_o,
  output logic [PAGE_W-1:0] pb_idx_o,
  output logic [7:0]        pb_data_o,
  output logic              cmt_o,
  output cmd_e              cmt_cmd_o,
  output logic [ADDR_W-1:0] cmt_addr_o,
  output logic [5:0]        cmt_field_o,
  output logic [PAGE_W:0]   cmt_cnt_o
);
  localparam logic [PAGE_W:0] PP_MAX = (PAGE_W+1)'(1 << PAGE_W);

  logic [2:0]        bit_q, bit_nx;
  logic [2:0]        byte_q, byte_nx;
  logic [7:0]        rx_q, rx_nx;
  cmd_e              cmd_q, cmd_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx, cur_a;
  logic [7:0]        wst_q, wst_nx;
  logic [PAGE_W:0]   ppc_q, ppc_nx;
  logic [7:0]        tx_q, tx_nx, tx_src;
  logic              pend_q, pend_nx, act_q, act_nx;
  logic [1:0]        idi_q, idi_nx;
  logic              rdr_q, rdr_nx, rdd_q;
  logic [ADDR_W-1:0] rda_q, rda_nx;
  logic [7:0]        rbuf_q;
  logic              cmt_q, cmt_nx;
  logic [7:0]        new_byte;
  logic [2:0]        dstart;

  assign new_byte = {rx_q[6:0], mosi_q};

  always_comb begin
    case (cmd_q)
      C_RDSR: tx_src = status_i;
      C_RDID: begin
        case (idi_q)
          2'd0:    tx_src = DEV_ID[23:16];
          2'd1:    tx_src = DEV_ID[15:8];
          default: tx_src = DEV_ID[7:0];
        endcase
      end
      default: tx_src = rbuf_q;
    endcase
  end

  // next-state
  always_comb begin
    bit_nx = bit_q;   byte_nx = byte_q; rx_nx = rx_q;   cmd_nx = cmd_q;
    addr_nx = addr_q; wst_nx = wst_q;   ppc_nx = ppc_q; tx_nx = tx_q;
    pend_nx = pend_q; act_nx = act_q;   idi_nx = idi_q; rda_nx = rda_q;
    rdr_nx = 1'b0;    cmt_nx = 1'b0;
    pb_we_o = 1'b0;   pb_idx_o = addr_q[PAGE_W-1:0] + ppc_q[PAGE_W-1:0];
    pb_data_o = new_byte;
    cur_a = addr_q;
    dstart = 3'd3;
    if (cs_fall) begin
      bit_nx = 3'd0; byte_nx = 3'd0; cmd_nx = C_NONE; pend_nx = 1'b0;
      act_nx = 1'b0; ppc_nx = '0;   idi_nx = 2'd0;
    end else if (cs_rise) begin
      act_nx  = 1'b0;
      pend_nx = 1'b0;
      cmt_nx  = is_write(cmd_q) && (bit_q == 3'd0) && (byte_q >= min_bytes(cmd_q));
    end else if (!cs_n_q) begin
      if (sck_rise) begin
        rx_nx  = new_byte;
        bit_nx = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (byte_q != 3'd7) byte_nx = byte_q + 3'd1;
          if (byte_q == 3'd0) cmd_nx = op_decode(new_byte, status_i[0], status_i[1]);
          if ((byte_q >= 3'd1) && (byte_q <= 3'd3)) cur_a = {addr_q[ADDR_W-9:0], new_byte};
          if (cmd_nx == C_FREAD) dstart = 3'd4;
          case (cmd_nx)
            C_RDSR, C_RDID: pend_nx = 1'b1;
            C_READ, C_FREAD: begin
              addr_nx = cur_a;
              if (byte_q >= dstart) begin
                rdr_nx  = 1'b1;
                rda_nx  = cur_a;
                addr_nx = cur_a + 1'b1;
                pend_nx = 1'b1;
              end
            end
            C_PP: begin
              addr_nx = cur_a;
              if (byte_q >= 3'd4) begin
                pb_we_o = 1'b1;
                if (ppc_q != PP_MAX) ppc_nx = ppc_q + 1'b1;
              end
            end
            C_SE:   addr_nx = cur_a;
            C_WRSR: if (byte_q == 3'd1) wst_nx = new_byte;
            default: ;
          endcase
        end
      end
      if (sck_fall) begin
        if (pend_q) begin
          tx_nx   = tx_src;
          pend_nx = 1'b0;
          act_nx  = 1'b1;
          if (cmd_q == C_RDID) idi_nx = (idi_q == 2'd2) ? 2'd0 : idi_q + 2'd1;
        end else begin
          tx_nx = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;  byte_q <= '0; rx_q <= '0;  cmd_q <= C_NONE;
      addr_q <= '0; wst_q <= '0;  ppc_q <= '0; tx_q <= '0;
      pend_q <= 1'b0; act_q <= 1'b0; idi_q <= '0; rda_q <= '0;
      rdr_q <= 1'b0;  rdd_q <= 1'b0; cmt_q <= 1'b0;
    end else begin
      bit_q <= bit_nx;   byte_q <= byte_nx; rx_q <= rx_nx;   cmd_q <= cmd_nx;
      addr_q <= addr_nx; wst_q <= wst_nx;   ppc_q <= ppc_nx; tx_q <= tx_nx;
      pend_q <= pend_nx; act_q <= act_nx;   idi_q <= idi_nx; rda_q <= rda_nx;
      rdr_q <= rdr_nx;   rdd_q <= rdr_q;    cmt_q <= cmt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rbuf_q <= '0;
    else if (rdd_q) rbuf_q <= rd_data_i;
  end

  assign miso_o      = tx_q[7];
  assign miso_oe_o   = act_q & ~cs_n_q;
  assign rd_req_o    = rdr_q;
  assign rd_addr_o   = rda_q;
  assign cmt_o       = cmt_q;
  assign cmt_cmd_o   = cmd_q;
  assign cmt_addr_o  = addr_q;
  assign cmt_field_o = wst_q[7:2];
  assign cmt_cnt_o   = ppc_q;

  AST_COMMIT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_q |-> ($past(bit_q) == 3'd0)); // R7
  AST_MISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o && $past(miso_oe_o) && !$past(sck_fall)) |-> $stable(miso_o)); // R1
endmodule

// File: rtl/sfc_exec.sv
module sfc_exec
  import sfc_pkg::*;
#(
  parameter int BUSY_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_i,
  input  cmd_e              cmt_cmd_i,
  input  logic [ADDR_W-1:0] cmt_addr_i,
  input  logic [5:0]        cmt_field_i,
  input  logic [PAGE_W:0]   cmt_cnt_i,
  input  logic              pb_we_i,
  input  logic [PAGE_W-1:0] pb_idx_i,
  input  logic [7:0]        pb_data_i,
  output logic [7:0]        status_o,
  output logic [ADDR_W-1:0] ex_addr_o,
  output logic              wr_req_o,
  output logic [7:0]        wr_data_o,
  output logic              ers_o,
  output logic              era_o
);
  localparam int CW    = $clog2(BUSY_CYCLES + 1);
  localparam int PAGES = 1 << PAGE_W;
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_WAIT} st_e;

  st_e                      st_q, st_nx;
  logic [CW-1:0]            cnt_q, cnt_nx;
  logic [PAGE_W:0]          left_q, left_nx;
  logic [PAGE_W-1:0]        off_q, off_nx;
  logic [ADDR_W-PAGE_W-1:0] page_q, page_nx;
  logic [ADDR_W-1:0]        ea_q, ea_nx;
  logic                     wel_q, wel_nx, ers_q, ers_nx, era_q, era_nx;
  logic [5:0]               fld_q, fld_nx;
  logic [7:0]               pbuf [PAGES];
  logic                     wip;

  always_ff @(posedge clk) begin
    if (pb_we_i) pbuf[pb_idx_i] <= pb_data_i;
  end

  always_comb begin
    st_nx = st_q;   cnt_nx = cnt_q; left_nx = left_q; off_nx = off_q;
    page_nx = page_q; ea_nx = ea_q; wel_nx = wel_q;   fld_nx = fld_q;
    ers_nx = 1'b0;  era_nx = 1'b0;
    case (st_q)
      S_IDLE: if (cmt_i) begin
        case (cmt_cmd_i)
          C_WREN: wel_nx = 1'b1;
          C_WRDI: wel_nx = 1'b0;
          C_WRSR: begin fld_nx = cmt_field_i; st_nx = S_WAIT; cnt_nx = CNT_LOAD; end
          C_SE:   begin ers_nx = 1'b1; ea_nx = cmt_addr_i; st_nx = S_WAIT; cnt_nx = CNT_LOAD; end
          C_BE:   begin era_nx = 1'b1; ea_nx = cmt_addr_i; st_nx = S_WAIT; cnt_nx = CNT_LOAD; end
          C_PP: begin
            st_nx   = S_PROG;
            off_nx  = cmt_addr_i[PAGE_W-1:0];
            page_nx = cmt_addr_i[ADDR_W-1:PAGE_W];
            left_nx = cmt_cnt_i;
          end
          default: ;
        endcase
      end
      S_PROG: begin
        off_nx  = off_q + 1'b1;
        left_nx = left_q - 1'b1;
        if (left_q == (PAGE_W+1)'(1)) begin
          st_nx  = S_WAIT;
          cnt_nx = CNT_LOAD;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_nx  = S_IDLE;
          wel_nx = 1'b0;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; left_q <= '0; off_q <= '0; page_q <= '0;
      ea_q <= '0; wel_q <= 1'b0; fld_q <= '0; ers_q <= 1'b0; era_q <= 1'b0;
    end else begin
      st_q <= st_nx; cnt_q <= cnt_nx; left_q <= left_nx; off_q <= off_nx;
      page_q <= page_nx; ea_q <= ea_nx; wel_q <= wel_nx; fld_q <= fld_nx;
      ers_q <= ers_nx; era_q <= era_nx;
    end
  end

  assign wip       = (st_q != S_IDLE);
  assign status_o  = {fld_q, wel_q, wip};
  assign wr_req_o  = (st_q == S_PROG);
  assign wr_data_o = pbuf[off_q];
  assign ex_addr_o = (st_q == S_PROG) ? {page_q, off_q} : ea_q;
  assign ers_o     = ers_q;
  assign era_o     = era_q;

  AST_WEL_DROPS_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel_q); // R11
  AST_GUARDED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_i && needs_wel(cmt_cmd_i)) |-> wel_q); // R8
  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_i |-> !wip); // R11
  AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_req_o, ers_q, era_q})); // R10
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import sfc_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          BUSY_CYCLES = 256,
  parameter logic [23:0] DEV_ID      = 24'hA53C19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sck,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic [23:0] mem_addr,
  output logic        mem_rd_req,
  input  logic [7:0]  mem_rd_data,
  output logic        mem_wr_req,
  output logic [7:0]  mem_wr_data,
  output logic        mem_erase_sector,
  output logic        mem_erase_all
);
  logic [1:0]        rst_q;
  logic              rst_s_n;
  logic              cs_n_q, cs_rise, cs_fall, sck_rise, sck_fall, mosi_q;
  logic [7:0]        status;
  logic [ADDR_W-1:0] rd_addr, ex_addr, cmt_addr;
  logic              pb_we, cmt;
  logic [PAGE_W-1:0] pb_idx;
  logic [7:0]        pb_data;
  cmd_e              cmt_cmd;
  logic [5:0]        cmt_field;
  logic [PAGE_W:0]   cmt_cnt;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  sfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_n_q_o(cs_n_q), .cs_rise_o(cs_rise), .cs_fall_o(cs_fall),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .mosi_q_o(mosi_q)
  );

  sfc_cmd #(.DEV_ID(DEV_ID)) u_cmd (
    .clk(clk), .rst_n(rst_s_n), .cs_n_q(cs_n_q), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_q(mosi_q), .status_i(status),
    .miso_o(spi_miso), .miso_oe_o(spi_miso_oe), .rd_req_o(mem_rd_req),
    .rd_addr_o(rd_addr), .rd_data_i(mem_rd_data), .pb_we_o(pb_we), .pb_idx_o(pb_idx),
    .pb_data_o(pb_data), .cmt_o(cmt), .cmt_cmd_o(cmt_cmd), .cmt_addr_o(cmt_addr),
    .cmt_field_o(cmt_field), .cmt_cnt_o(cmt_cnt)
  );

  sfc_exec #(.BUSY_CYCLES(BUSY_CYCLES)) u_exec (
    .clk(clk), .rst_n(rst_s_n), .cmt_i(cmt), .cmt_cmd_i(cmt_cmd), .cmt_addr_i(cmt_addr),
    .cmt_field_i(cmt_field), .cmt_cnt_i(cmt_cnt), .pb_we_i(pb_we), .pb_idx_i(pb_idx),
    .pb_data_i(pb_data), .status_o(status), .ex_addr_o(ex_addr), .wr_req_o(mem_wr_req),
    .wr_data_o(mem_wr_data), .ers_o(mem_erase_sector), .era_o(mem_erase_all)
  );

  assign mem_addr = status[0] ? ex_addr : rd_addr;
endmodule

// File: tb/sim_spi_flash_cmd_engine.sv
module sim_spi_flash_cmd_engine;
  localparam int          HALF = 8;
  localparam int          GAP  = 24;
  localparam logic [23:0] ID   = 24'hA53C19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [23:0] mem_addr;
  logic        mem_rd_req, mem_wr_req, mem_erase_sector, mem_erase_all;
  logic [7:0]  mem_rd_data = 8'h00;
  logic [7:0]  mem_wr_data;

  int n_run = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  logic [8:0] rx_q[$];
  string      tag_q[$];
  logic [7:0] mem [int unsigned];

  always #5 clk = ~clk;

  spi_flash_cmd_engine #(.BUSY_CYCLES(2000), .DEV_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .mem_addr(mem_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_data(mem_wr_data), .mem_erase_sector(mem_erase_sector),
    .mem_erase_all(mem_erase_all)
  );

  // behavioural array backend, erased value 0xFF
  always @(posedge clk) begin
    if (mem_rd_req)
      mem_rd_data <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF;
    if (mem_wr_req) mem[int'(mem_addr)] = mem_wr_data;
    if (mem_erase_all) mem.delete();
    if (mem_erase_sector) begin
      int unsigned kq[$];
      foreach (mem[k]) if ((k >> 16) == int'(mem_addr[23:16])) kq.push_back(k);
      foreach (kq[i]) mem.delete(kq[i]);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // monitor: compares each returned byte with the next expected item
  initial forever begin
    @(negedge clk);
    while (rx_q.size() > 0 && exp_q.size() > 0) begin
      logic [8:0] g, e;
      string t;
      g = rx_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(g === e, t, g, e);
    end
  end

  task automatic spi_bit(input logic b, output logic r, output logic oe);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso; oe = spi_miso_oe;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    logic r, o;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], r, o);
      rx[i] = r;
      oe_all &= o;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); spi_cs_n = 1'b0;
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] r; logic o;
    spi_byte(b, r, o);
  endtask

  task automatic put_addr(input logic [23:0] a);
    put(a[23:16]); put(a[15:8]); put(a[7:0]);
  endtask

  // driver: expected byte goes into the scoreboard before the byte is clocked
  task automatic expect_b(input logic [7:0] e, input string tag);
    logic [7:0] r; logic o;
    exp_q.push_back({1'b1, e}); tag_q.push_back(tag);
    spi_byte(8'h00, r, o);
    rx_q.push_back({o, r});
  endtask

  task automatic one_op(input logic [7:0] op);
    cs_lo(); put(op); cs_hi();
  endtask

  task automatic wait_idle(output logic [7:0] st);
    logic o;
    st = 8'h01;
    for (int i = 0; i < 60 && st[0]; i++) begin
      cs_lo(); put(8'h05); spi_byte(8'h00, st, o); cs_hi();
    end
  endtask

  logic [7:0] st, rb;
  logic       oe, rbit;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state of the drive enable
    chk(spi_miso_oe === 1'b0, "R1 oe after reset", {8'h0, spi_miso_oe}, 9'h0);
    // R3 status after reset
    cs_lo(); put(8'h05); expect_b(8'h00, "R3 status reset"); cs_hi();
    // R4 identification, with repeat; R2 opcode 0x9F
    cs_lo(); put(8'h9F);
    expect_b(ID[23:16], "R4 id0"); expect_b(ID[15:8], "R4 id1");
    expect_b(ID[7:0], "R4 id2");   expect_b(ID[23:16], "R2 R4 id wrap");
    cs_hi();
    // R6 write enable, R3 repeated status
    one_op(8'h06);
    cs_lo(); put(8'h05); expect_b(8'h02, "R6 WEL set"); expect_b(8'h02, "R3 status repeat"); cs_hi();
    one_op(8'h04);
    cs_lo(); put(8'h05); expect_b(8'h00, "R6 WEL cleared"); cs_hi();
    // R7 write enable with one extra clock is rejected
    cs_lo(); put(8'h06); spi_bit(1'b0, rbit, oe); cs_hi();
    cs_lo(); put(8'h05); expect_b(8'h00, "R7 misaligned WREN"); cs_hi();
    // R8 program without write enable
    cs_lo(); put(8'h02); put_addr(24'h000010); put(8'h55); cs_hi();
    cs_lo(); put(8'h05); expect_b(8'h00, "R8 no busy"); cs_hi();
    cs_lo(); put(8'h03); put_addr(24'h000010); expect_b(8'hFF, "R8 unprogrammed"); cs_hi();
    // R11 program, busy status, ignored read during busy
    one_op(8'h06);
    cs_lo(); put(8'h02); put_addr(24'h000010); put(8'hA1); put(8'hB2); put(8'hC3); cs_hi();
    cs_lo(); put(8'h05); expect_b(8'h03, "R11 busy+WEL"); expect_b(8'h03, "R3 poll while busy"); cs_hi();
    cs_lo(); put(8'h03); put_addr(24'h000010); spi_byte(8'h00, rb, oe); cs_hi();
    chk(oe === 1'b0, "R11 read ignored while busy", {8'h0, oe}, 9'h0);
    wait_idle(st);
    chk(st === 8'h00, "R11 idle clears WEL", {1'b0, st}, 9'h000);
    // R5 read with auto-increment, fast read with dummy byte
    cs_lo(); put(8'h03); put_addr(24'h000010);
    expect_b(8'hA1, "R5 read0"); expect_b(8'hB2, "R5 read1");
    expect_b(8'hC3, "R5 read2"); expect_b(8'hFF, "R5 read3");
    cs_hi();
    cs_lo(); put(8'h0B); put_addr(24'h000011); put(8'h00);
    expect_b(8'hB2, "R5 fast0"); expect_b(8'hC3, "R5 fast1");
    cs_hi();
    // R9 page wrap
    one_op(8'h06);
    cs_lo(); put(8'h02); put_addr(24'h0001FE); put(8'h11); put(8'h22); put(8'h33); cs_hi();
    wait_idle(st);
    cs_lo(); put(8'h03); put_addr(24'h0001FE); expect_b(8'h11, "R9 off FE"); expect_b(8'h22, "R9 off FF"); cs_hi();
    cs_lo(); put(8'h03); put_addr(24'h000100); expect_b(8'h33, "R9 wrapped to 00"); cs_hi();
    cs_lo(); put(8'h03); put_addr(24'h000200); expect_b(8'hFF, "R9 next page untouched"); cs_hi();
    // R7 program with 3 extra clocks is rejected; WEL survives
    one_op(8'h06);
    cs_lo(); put(8'h02); put_addr(24'h000020); put(8'h77);
    for (int i = 0; i < 3; i++) spi_bit(1'b1, rbit, oe);
    cs_hi();
    cs_lo(); put(8'h05); expect_b(8'h02, "R7 rejected PP no busy"); cs_hi();
    cs_lo(); put(8'h03); put_addr(24'h000020); expect_b(8'hFF, "R7 rejected PP no data"); cs_hi();
    one_op(8'h04);
    // R12 unknown opcode
    cs_lo(); put(8'hAB); spi_byte(8'h00, rb, oe); cs_hi();
    chk(oe === 1'b0, "R12 unknown opcode not driven", {8'h0, oe}, 9'h0);
    cs_lo(); put(8'h05); expect_b(8'h00, "R12 status after unknown"); cs_hi();
    // R12 abort mid byte
    cs_lo(); put(8'h03); put_addr(24'h000010);
    for (int i = 0; i < 4; i++) spi_bit(1'b0, rbit, oe);
    cs_hi();
    chk(spi_miso_oe === 1'b0, "R1 oe released on CS high", {8'h0, spi_miso_oe}, 9'h0);
    cs_lo(); put(8'h03); put_addr(24'h000010); expect_b(8'hA1, "R12 read after abort"); cs_hi();
    // R10 sector clear leaves other sector
    one_op(8'h06);
    cs_lo(); put(8'h02); put_addr(24'h020005); put(8'h9C); cs_hi();
    wait_idle(st);
    one_op(8'h06);
    cs_lo(); put(8'hD8); put_addr(24'h000000); cs_hi();
    wait_idle(st);
    cs_lo(); put(8'h03); put_addr(24'h000010); expect_b(8'hFF, "R10 sector cleared"); cs_hi();
    cs_lo(); put(8'h03); put_addr(24'h020005); expect_b(8'h9C, "R10 other sector kept"); cs_hi();
    // R10 full clear
    one_op(8'h06);
    one_op(8'hC7);
    wait_idle(st);
    cs_lo(); put(8'h03); put_addr(24'h020005); expect_b(8'hFF, "R10 full clear"); cs_hi();
    // R10 status write
    one_op(8'h06);
    cs_lo(); put(8'h01); put(8'hFF); cs_hi();
    wait_idle(st);
    chk(st === 8'hFC, "R10 status field written", {1'b0, st}, {1'b0, 8'hFC});

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule